// File: doc/BRIEF.md
# Threshold-Based Interrupt Status Controller

This block gathers the interrupt sources of a FIFO-based serial controller and presents them through a simple 32-bit register port. Two sources depend on FIFO levels. The receive-level flag is set while the receive FIFO holds at least a programmed number of entries. The transmit-level flag is set while the transmit FIFO holds no more than a programmed number of entries. With that threshold at zero, the transmit flag fires each time the FIFO drains, so software can refill it before it runs dry. Four more sources are events that arrive as one-cycle pulses: stop seen, start seen, transfer aborted and receive overflow. Each pulse sets a sticky bit.

Software reads a raw status word, a mask, and a masked status word. A single interrupt line is the OR of the masked bits. Each event has its own read-to-clear register, so reading it clears that event alone and cannot lose a different event that arrives at the same moment. A combined read-to-clear register also exists and clears every event at once. The two level flags follow the FIFO levels and no clear register affects them. All accesses are whole 32-bit words.

Register map (byte offsets): 0x00 raw status, 0x04 mask, 0x08 masked status, 0x0C receive threshold, 0x10 transmit threshold, 0x14 clear all events, and 0x18/0x1C/0x20/0x24 clear stop/start/abort/overflow. Status bit positions are: bit 0 receive level, bit 1 transmit level, bit 2 stop, bit 3 start, bit 4 abort, bit 5 overflow.

Top module: `irq_status_ctrl`

## Requirements
- R1: After synchronous reset, the mask reads 0x1 (only the receive-level source enabled), the receive threshold reads 1, the transmit threshold reads 0, all event bits are clear and the interrupt line is low.
- R2: Raw status bit 0 is 1 in the cycle after the receive level is greater than or equal to the receive threshold, and 0 otherwise.
- R3: Raw status bit 1 is 1 in the cycle after the transmit level is less than or equal to the transmit threshold, and 0 otherwise.
- R4: An event pulse on evt_pulse[k] sets raw status bit 2+k from the next cycle. The bit stays set until a clear read.
- R5: A read of the clear register for event k (offset 0x18+4k) returns the bit's value before the clear in bit 0 and zero in bits 31:1. It clears only that event.
- R6: A read of offset 0x14 returns the OR of all event bits before the clear in bit 0. It clears every event bit.
- R7: If an event pulse arrives in the same cycle as a clear read of that event, the event stays set.
- R8: Clear reads never change raw status bits 1:0.
- R9: Offset 0x08 reads raw status AND mask. The irq output equals the OR of raw status AND mask, delayed by one cycle.
- R10: Only word-aligned accesses (address bits 1:0 equal to 0) take effect. A misaligned read returns 0. Writes to read-only or clear offsets change nothing, and unmapped offsets read 0.
- R11: Read data appears on rdata in the cycle after the read strobe. rdata is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| evt_pulse | input | NUM_EVT | One-cycle event pulses (stop, start, abort, overflow) |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check the behaviour of each event bit: set on a pulse, held without a clear, dropped by a clear with no pulse, and kept when a pulse and a clear coincide. They also check the comparison of each level flag against its threshold, the relation between the masked status and the interrupt line, and that rdata is zero on idle cycles. Only the bench scenarios can show behaviour that depends on bus decoding: which offset clears which bit, the value returned before the clear, that level bits survive a combined clear, and that misaligned or read-only writes leave the state untouched.

// File: rtl/isc_pkg.sv
package isc_pkg;
  // word indices of the register map (byte offset / 4)
  localparam int unsigned IDX_RAW    = 0;
  localparam int unsigned IDX_MASK   = 1;
  localparam int unsigned IDX_MSTAT  = 2;
  localparam int unsigned IDX_RXTHR  = 3;
  localparam int unsigned IDX_TXTHR  = 4;
  localparam int unsigned IDX_CLRALL = 5;
  localparam int unsigned IDX_CLR0   = 6;

  // status bit positions
  localparam int unsigned BIT_RXLVL  = 0;
  localparam int unsigned BIT_TXLVL  = 1;
  localparam int unsigned NUM_LVL    = 2;
  localparam int unsigned BUS_W      = 32;
endpackage

// File: rtl/isc_level_flag.sv
module isc_level_flag #(
  parameter int unsigned LVL_W = 6,
  parameter bit          AT_OR_ABOVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             flag_o
);
  logic hit;

  generate
    if (AT_OR_ABOVE) begin : g_ge
      assign hit = (level_i >= thr_i);
    end else begin : g_le
      assign hit = (level_i <= thr_i);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= hit;
  end

  generate
    if (AT_OR_ABOVE) begin : g_chk_ge
      // R2
      rx_level_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (level_i >= thr_i) |=> flag_o);
    end else begin : g_chk_le
      // R3
      tx_level_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (level_i > thr_i) |=> !flag_o);
    end
  endgenerate
endmodule

// File: rtl/isc_evt_bit.sv
module isc_evt_bit (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (evt_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> pend_o);
  // R5
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !evt_i) |=> !pend_o);
  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/isc_regs.sv
module isc_regs
  import isc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned LVL_W   = 6,
  parameter int unsigned NUM_EVT = 4,
  localparam int unsigned NUM_SRC = NUM_LVL + NUM_EVT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic [NUM_SRC-1:0] raw_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [LVL_W-1:0]   rx_thr_o,
  output logic [LVL_W-1:0]   tx_thr_o,
  output logic [NUM_EVT-1:0] clr_evt_o,
  output logic               clr_all_o,
  output logic [BUS_W-1:0]   rdata_o
);
  logic        aligned, wr_en, rd_en;
  int unsigned idx;
  logic [BUS_W-1:0] rd_val;
  logic        wdata_unused;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_sel &  bus_we & aligned;
  assign rd_en   = bus_sel & !bus_we & aligned;
  assign idx     = int'(bus_addr[ADDR_W-1:2]);
  assign wdata_unused = ^bus_wdata;

  assign clr_all_o = rd_en && (idx == IDX_CLRALL);

  genvar k;
  generate
    for (k = 0; k < NUM_EVT; k++) begin : g_clr
      assign clr_evt_o[k] = rd_en && (idx == IDX_CLR0 + k);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o   <= NUM_SRC'(1);
      rx_thr_o <= LVL_W'(1);
      tx_thr_o <= '0;
    end else if (wr_en) begin
      if (idx == IDX_MASK)  mask_o   <= bus_wdata[NUM_SRC-1:0];
      if (idx == IDX_RXTHR) rx_thr_o <= bus_wdata[LVL_W-1:0];
      if (idx == IDX_TXTHR) tx_thr_o <= bus_wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (idx == IDX_RAW)        rd_val[NUM_SRC-1:0] = raw_i;
    else if (idx == IDX_MASK)  rd_val[NUM_SRC-1:0] = mask_o;
    else if (idx == IDX_MSTAT) rd_val[NUM_SRC-1:0] = raw_i & mask_o;
    else if (idx == IDX_RXTHR) rd_val[LVL_W-1:0]   = rx_thr_o;
    else if (idx == IDX_TXTHR) rd_val[LVL_W-1:0]   = tx_thr_o;
    else if (idx == IDX_CLRALL) rd_val[0] = |raw_i[NUM_SRC-1:NUM_LVL];
    else begin
      for (int e = 0; e < NUM_EVT; e++) begin
        if (idx == IDX_CLR0 + e) rd_val[0] = raw_i[NUM_LVL+e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_val;
    else            rdata_o <= '0;
  end

  // R11
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata_o == '0));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned LVL_W   = 6,
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq
);
  localparam int unsigned NUM_SRC = NUM_LVL + NUM_EVT;

  logic [NUM_SRC-1:0] raw, mask;
  logic [LVL_W-1:0]   rx_thr, tx_thr;
  logic [NUM_EVT-1:0] clr_evt, evt_bits;
  logic               clr_all;
  logic               rx_flag, tx_flag;

  isc_regs #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .NUM_EVT(NUM_EVT)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .raw_i(raw),
    .mask_o(mask), .rx_thr_o(rx_thr), .tx_thr_o(tx_thr),
    .clr_evt_o(clr_evt), .clr_all_o(clr_all), .rdata_o(bus_rdata)
  );

  isc_level_flag #(.LVL_W(LVL_W), .AT_OR_ABOVE(1'b1)) u_rx_flag (
    .clk(clk), .rst(rst), .level_i(rx_level), .thr_i(rx_thr), .flag_o(rx_flag)
  );

  isc_level_flag #(.LVL_W(LVL_W), .AT_OR_ABOVE(1'b0)) u_tx_flag (
    .clk(clk), .rst(rst), .level_i(tx_level), .thr_i(tx_thr), .flag_o(tx_flag)
  );

  genvar k;
  generate
    for (k = 0; k < NUM_EVT; k++) begin : g_evt
      isc_evt_bit u_bit (
        .clk(clk), .rst(rst),
        .evt_i(evt_pulse[k]),
        .clr_i(clr_evt[k] | clr_all),
        .pend_o(evt_bits[k])
      );
    end
  endgenerate

  assign raw[BIT_RXLVL] = rx_flag;
  assign raw[BIT_TXLVL] = tx_flag;
  assign raw[NUM_SRC-1:NUM_LVL] = evt_bits;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw & mask);
  end

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw & mask) == '0) |=> !irq);
  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw & mask) != '0) |=> irq);
  // R6
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_all && (evt_pulse == '0)) |=> (evt_bits == '0));
endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 7;
  localparam int LVL_W = 6;
  localparam int NUM_EVT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
  logic [NUM_EVT-1:0] evt_pulse = '0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .NUM_EVT(NUM_EVT)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_level(rx_level), .tx_level(tx_level), .evt_pulse(evt_pulse), .irq(irq)
  );

  // behavioural reference model
  int m_lvl, m_evt, m_mask, m_rxthr, m_txthr, m_rdata;
  bit m_irq;

  always @(posedge clk) begin
    int raw, rv, idx, evt_n;
    bit acc_rd, acc_wr;
    if (rst) begin
      m_lvl = 0; m_evt = 0; m_mask = 1; m_rxthr = 1; m_txthr = 0;
      m_rdata = 0; m_irq = 0;
    end else begin
      raw = m_lvl + (m_evt * 4);
      idx = int'(bus_addr) / 4;
      acc_rd = bus_sel && !bus_we && (bus_addr % 4 == 0);
      acc_wr = bus_sel && bus_we && (bus_addr % 4 == 0);
      rv = 0;
      evt_n = m_evt;
      if (acc_rd) begin
        case (idx)
          0: rv = raw;
          1: rv = m_mask;
          2: rv = raw & m_mask;
          3: rv = m_rxthr;
          4: rv = m_txthr;
          5: begin rv = (m_evt != 0) ? 1 : 0; evt_n = 0; end
          6, 7, 8, 9: begin
            rv = (m_evt >> (idx - 6)) & 1;
            evt_n = m_evt & ~(1 << (idx - 6));
          end
          default: rv = 0;
        endcase
      end
      evt_n = evt_n | int'(evt_pulse);
      m_irq = (raw & m_mask) != 0;
      m_lvl = ((int'(rx_level) >= m_rxthr) ? 1 : 0) + ((int'(tx_level) <= m_txthr) ? 2 : 0);
      if (acc_wr) begin
        if (idx == 1) m_mask = int'(bus_wdata[5:0]);
        if (idx == 3) m_rxthr = int'(bus_wdata[LVL_W-1:0]);
        if (idx == 4) m_txthr = int'(bus_wdata[LVL_W-1:0]);
      end
      m_evt = evt_n;
      m_rdata = rv;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(bus_rdata) != m_rdata || irq != m_irq) begin
        fails++;
        $display("FAIL model R11/R9: rdata=%h irq=%0d expected rdata=%h irq=%0d",
                 bus_rdata, irq, m_rdata, m_irq);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = ADDR_W'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input int addr, input int exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    bus_sel = 0;
    chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
  endtask

  task automatic pulse(input int v);
    @(negedge clk);
    evt_pulse = NUM_EVT'(v);
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic pulse_rd(input int v, input int addr, input int exp, input string tag);
    @(negedge clk);
    evt_pulse = NUM_EVT'(v); bus_sel = 1; bus_we = 0; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    evt_pulse = '0; bus_sel = 0;
    chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 0;
    idle(2);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    rd(32'h04, 32'h1, "R1 mask");
    rd(32'h0C, 1, "R1 rx thr");
    rd(32'h10, 0, "R1 tx thr");
    rd(32'h00, 32'h2, "R1 raw");
    // R2 receive level flag
    tx_level = 5; rx_level = 3;
    idle(2);
    rd(32'h00, 32'h1, "R2 rx over thr");
    chk(irq == 1'b1, "R9 irq rx", int'(irq), 1);
    wr(32'h0C, 4);
    idle(2);
    rd(32'h00, 32'h0, "R2 rx below thr");
    rx_level = 4;
    idle(2);
    rd(32'h00, 32'h1, "R2 rx equal thr");
    rx_level = 0;
    // R3 transmit level flag
    wr(32'h10, 5);
    idle(2);
    rd(32'h00, 32'h2, "R3 tx equal thr");
    tx_level = 6;
    idle(2);
    rd(32'h00, 32'h0, "R3 tx above thr");
    // R4 sticky events
    pulse(1);
    idle(3);
    rd(32'h00, 32'h4, "R4 stop sticky");
    pulse(2);
    rd(32'h00, 32'hC, "R4 start sticky");
    // R5 per-event clear
    rd(32'h18, 1, "R5 clear stop pre");
    rd(32'h00, 32'h8, "R5 start kept");
    rd(32'h18, 0, "R5 clear stop again");
    // R6 / R8 combined clear
    rx_level = 4;
    pulse(5);
    idle(1);
    rd(32'h00, 32'h1D, "R6 before clear-all");
    rd(32'h14, 1, "R6 clear-all pre");
    rd(32'h00, 32'h1, "R8 level kept");
    rd(32'h14, 0, "R6 clear-all empty");
    // R7 set wins
    pulse_rd(8, 32'h24, 0, "R7 clear pre");
    rd(32'h00, 32'h21, "R7 event kept");
    rd(32'h24, 1, "R7 clear later");
    rd(32'h00, 32'h1, "R5 overflow cleared");
    // R9 masked status and irq
    wr(32'h04, 32'h3C);
    pulse(4);
    idle(1);
    rd(32'h08, 32'h10, "R9 masked");
    chk(irq == 1'b1, "R9 irq abort", int'(irq), 1);
    wr(32'h04, 0);
    idle(2);
    chk(irq == 1'b0, "R9 irq masked off", int'(irq), 0);
    rd(32'h08, 0, "R9 masked zero");
    // R10 ignored accesses
    wr(32'h00, 32'hFFFFFFFF);
    wr(32'h20, 32'hFFFFFFFF);
    wr(32'h05, 32'h3F);
    rd(32'h00, 32'h11, "R10 raw untouched");
    rd(32'h04, 0, "R10 misaligned write");
    rd(32'h40, 0, "R10 unmapped");
    rd(32'h21, 0, "R10 misaligned read");
    rd(32'h00, 32'h11, "R10 misaligned read no clear");
    // R11 idle rdata
    idle(1);
    chk(bus_rdata == 32'h0, "R11 idle", int'(bus_rdata), 0);
    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule